// File: doc/BRIEF.md
# Module Reset Register Block

This block holds one software-controlled reset line for each of up to 64 peripheral modules and exposes them through a small 32-bit register port. Lines are grouped into banks of 32: line n sits in bank n/32 at bit n mod 32. Software asserts a module's reset by writing a register, waits as long as it likes, then releases it. The block adds no delay of its own and never times out a line.

A parameter picks one of two register layouts. In the direct layout each bank is a single read-write word at byte offset 4·k. Software changes one line by reading the word, editing one bit and writing the word back. In the set/clear layout each bank has a set word at 8·k and a clear word at 8·k+4. Writing a one to a set bit asserts that line, writing a one to a clear bit releases it, and zero bits leave lines as they are. Reading either word of the pair returns the bank's current line state.

Bit 31 of bank 0 is the whole-system reset request. A small state machine with states SYS_IDLE and SYS_PULSE turns a written one into a single-cycle pulse. The transitions are:
- SYS_IDLE to SYS_PULSE when a request is written.
- SYS_PULSE to SYS_IDLE when no new request arrives.
- SYS_PULSE to SYS_PULSE when requests are written on back-to-back cycles.

The stored bit therefore clears itself.

Top module: `modrst_ctrl`

## Requirements
- R1: While and after the block's reset, every module reset output and the system-reset output are 0.
- R2: Line n drives output bit n of `mod_rst_o`; lines 0 to 31 are bits 0 to 31 of bank 0, lines 32 to 63 are bits 0 to 31 of bank 1.
- R3: Direct layout: a write to byte offset 4·k loads bank k; a 1 bit asserts that line and a 0 bit releases it.
- R4: Direct layout: a read of offset 4·k returns the current state of all 32 bits of bank k, so a read-modify-write touches only the edited line.
- R5: Set/clear layout: a 1 written to a bit at offset 8·k asserts that line, a 1 written to a bit at offset 8·k+4 releases it, and 0 bits in either write leave lines unchanged.
- R6: Set/clear layout: a read of either 8·k or 8·k+4 returns the current state of bank k.
- R7: Outputs change only on the clock edge that accepts a write and then hold, for any number of cycles, until another write changes them.
- R8: Writing 1 to bit 31 of the bank 0 word (the set word in the set/clear layout) drives `sys_rst_o` and `mod_rst_o[31]` high for exactly one cycle after the accepting edge; that bit then reads back 0.
- R9: Writes to any offset that is not a defined register word (including unaligned offsets) change nothing, and reads of such offsets return 0.
- R10: With the write enable low, address and write data have no effect on any line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| bus_addr_i | input | ADDR_W | Byte address of the register access |
| bus_we_i | input | 1 | Write enable, sampled on the rising clock edge |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational from registered state |
| mod_rst_o | output | 32·NUM_BANKS | Registered module reset lines, 1 = held in reset |
| sys_rst_o | output | 1 | Single-cycle system reset pulse |

## Verification
On every cycle, the assertions check several cycle-level properties. A set strobe raises its line on the next edge and a lone clear strobe drops it. With no strobe, every stored line stays put. The system pulse follows each request by one cycle and never lasts longer unless a new request arrives. Reset forces all outputs low. Only the bench's scenarios can show the rest. These are the address map of each layout, the agreement of reads with the line state through whole read-modify-write sweeps over all 63 module lines, the silence of undefined offsets, and the read-back of the self-clearing system bit.

// File: rtl/modrst_pkg.sv
`timescale 1ns/1ps
package modrst_pkg;
    typedef enum logic {
        MR_DIRECT = 1'b0,
        MR_SETCLR = 1'b1
    } mr_layout_e;

    typedef enum logic {
        SYS_IDLE  = 1'b0,
        SYS_PULSE = 1'b1
    } sys_state_e;

    localparam int unsigned MR_WORD_W  = 32;
    localparam int unsigned MR_SYS_BIT = 31;

    // Byte offset of the word that asserts (or loads) bank k.
    function automatic int unsigned mr_set_off(mr_layout_e lay, int unsigned k);
        return (lay == MR_SETCLR) ? 8 * k : 4 * k;
    endfunction

    // Byte offset of the release word of bank k (pair layout only).
    function automatic int unsigned mr_clr_off(int unsigned k);
        return 8 * k + 4;
    endfunction
endpackage

// File: rtl/modrst_decode.sv
`timescale 1ns/1ps
module modrst_decode
    import modrst_pkg::*;
#(
    parameter mr_layout_e  LAYOUT    = MR_DIRECT,
    parameter int unsigned NUM_BANKS = 2,
    parameter int unsigned ADDR_W    = 12,
    localparam int unsigned SEL_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [ADDR_W-1:0]                     addr_i,
    input  logic                                  we_i,
    input  logic [MR_WORD_W-1:0]                  wdata_i,
    output logic [NUM_BANKS-1:0][MR_WORD_W-1:0]   set_o,
    output logic [NUM_BANKS-1:0][MR_WORD_W-1:0]   clr_o,
    output logic                                  rd_hit_o,
    output logic [SEL_W-1:0]                      rd_sel_o
);
    always_comb begin
        set_o    = '0;
        clr_o    = '0;
        rd_hit_o = 1'b0;
        rd_sel_o = '0;
        for (int unsigned k = 0; k < NUM_BANKS; k++) begin
            if (addr_i == ADDR_W'(mr_set_off(LAYOUT, k))) begin
                rd_hit_o = 1'b1;
                rd_sel_o = SEL_W'(k);
                if (we_i) begin
                    set_o[k] = wdata_i;
                    if (LAYOUT == MR_DIRECT) begin
                        clr_o[k] = ~wdata_i;
                    end
                end
            end
            if ((LAYOUT == MR_SETCLR) && (addr_i == ADDR_W'(mr_clr_off(k)))) begin
                rd_hit_o = 1'b1;
                rd_sel_o = SEL_W'(k);
                if (we_i) begin
                    clr_o[k] = wdata_i;
                end
            end
        end
    end

    // R10: an idle bus produces no strobe at all
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |-> (set_o == '0 && clr_o == '0));
endmodule

// File: rtl/modrst_bank.sv
`timescale 1ns/1ps
module modrst_bank
    import modrst_pkg::*;
#(
    parameter bit HAS_SYS = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [MR_WORD_W-1:0] set_i,
    input  logic [MR_WORD_W-1:0] clr_i,
    input  logic                 sys_i,
    output logic [MR_WORD_W-1:0] q_o
);
    localparam logic [MR_WORD_W-1:0] FLOP_MASK =
        HAS_SYS ? ~(MR_WORD_W'(1) << MR_SYS_BIT) : '1;

    for (genvar b = 0; b < MR_WORD_W; b++) begin : g_bit
        if (HAS_SYS && (b == MR_SYS_BIT)) begin : g_sys
            logic unused_strobe;
            assign unused_strobe = set_i[b] ^ clr_i[b];
            assign q_o[b] = sys_i;
        end else begin : g_ff
            logic line_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    line_q <= 1'b0;
                end else if (set_i[b]) begin
                    line_q <= 1'b1;
                end else if (clr_i[b]) begin
                    line_q <= 1'b0;
                end
            end
            assign q_o[b] = line_q;
        end
    end

    if (!HAS_SYS) begin : g_nosys
        logic unused_sys;
        assign unused_sys = sys_i;
    end

    // R5: a set strobe raises its line on the next edge
    p_set_raises_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_i & FLOP_MASK) != '0) |=>
        ((q_o & $past(set_i & FLOP_MASK)) == $past(set_i & FLOP_MASK)));

    // R3: a clear strobe without a set drops its line on the next edge
    p_clr_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~set_i & FLOP_MASK) != '0) |=>
        ((q_o & $past(clr_i & ~set_i & FLOP_MASK)) == '0));

    // R7: with no strobe, stored lines hold
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (((set_i | clr_i) & FLOP_MASK) == '0) |=> $stable(q_o & FLOP_MASK));
endmodule

// File: rtl/modrst_sysreq.sv
`timescale 1ns/1ps
module modrst_sysreq
    import modrst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic pulse_o
);
    sys_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SYS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            SYS_IDLE:  state_d = req_i ? SYS_PULSE : SYS_IDLE;
            SYS_PULSE: state_d = req_i ? SYS_PULSE : SYS_IDLE;
            default:   state_d = SYS_IDLE;
        endcase
    end

    always_comb begin
        pulse_o = (state_q == SYS_PULSE);
    end

    // R8: a request yields the pulse on the following cycle
    p_req_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> pulse_o);

    // R8: the pulse lasts one cycle unless requested again
    p_single_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_o && !req_i) |=> !pulse_o);
endmodule

// File: rtl/modrst_ctrl.sv
`timescale 1ns/1ps
module modrst_ctrl
    import modrst_pkg::*;
#(
    parameter mr_layout_e  LAYOUT    = MR_DIRECT,
    parameter int unsigned NUM_BANKS = 2,
    parameter int unsigned ADDR_W    = 12,
    localparam int unsigned LINES    = NUM_BANKS * MR_WORD_W,
    localparam int unsigned SEL_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic                 bus_we_i,
    input  logic [MR_WORD_W-1:0] bus_wdata_i,
    output logic [MR_WORD_W-1:0] bus_rdata_o,
    output logic [LINES-1:0]     mod_rst_o,
    output logic                 sys_rst_o
);
    logic [NUM_BANKS-1:0][MR_WORD_W-1:0] set_s;
    logic [NUM_BANKS-1:0][MR_WORD_W-1:0] clr_s;
    logic [NUM_BANKS-1:0][MR_WORD_W-1:0] bank_q;
    logic                                rd_hit;
    logic [SEL_W-1:0]                    rd_sel;
    logic                                sys_pulse;

    modrst_decode #(
        .LAYOUT    (LAYOUT),
        .NUM_BANKS (NUM_BANKS),
        .ADDR_W    (ADDR_W)
    ) u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (bus_addr_i),
        .we_i     (bus_we_i),
        .wdata_i  (bus_wdata_i),
        .set_o    (set_s),
        .clr_o    (clr_s),
        .rd_hit_o (rd_hit),
        .rd_sel_o (rd_sel)
    );

    modrst_sysreq u_sysreq (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (set_s[0][MR_SYS_BIT]),
        .pulse_o (sys_pulse)
    );

    for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
        modrst_bank #(
            .HAS_SYS (k == 0)
        ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_s[k]),
            .clr_i (clr_s[k]),
            .sys_i (sys_pulse),
            .q_o   (bank_q[k])
        );
        assign mod_rst_o[k*MR_WORD_W +: MR_WORD_W] = bank_q[k];
    end

    assign sys_rst_o   = sys_pulse;
    assign bus_rdata_o = rd_hit ? bank_q[rd_sel] : '0;

    // R1: reset leaves every output low on the next edge
    p_reset_low_r1: assert property (@(posedge clk)
        !rst_n |=> (mod_rst_o == '0 && !sys_rst_o));

    // R9: an unmapped read returns zero
    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |-> (bus_rdata_o == '0));
endmodule

// File: tb/modrst_ctrl_tb.sv
`timescale 1ns/1ps
module modrst_ctrl_tb;
    import modrst_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        we_d = 1'b0;
    logic        we_s = 1'b0;
    logic [31:0] rdata_d, rdata_s;
    logic [63:0] lines_d, lines_s;
    logic        sys_d, sys_s;

    logic [63:0] m_d = '0;
    logic [63:0] m_s = '0;
    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    modrst_ctrl #(.LAYOUT(MR_DIRECT), .NUM_BANKS(2), .ADDR_W(12)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr_i(addr), .bus_we_i(we_d),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata_d), .mod_rst_o(lines_d),
        .sys_rst_o(sys_d));

    modrst_ctrl #(.LAYOUT(MR_SETCLR), .NUM_BANKS(2), .ADDR_W(12)) u_dut_sc (
        .clk(clk), .rst_n(rst_n), .bus_addr_i(addr), .bus_we_i(we_s),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata_s), .mod_rst_o(lines_s),
        .sys_rst_o(sys_s));

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input bit sc, input logic [11:0] a);
        logic [63:0] m;
        m = sc ? m_s : m_d;
        if (!sc) begin
            if (a == 12'h000) return m[31:0];
            if (a == 12'h004) return m[63:32];
        end else begin
            if (a == 12'h000 || a == 12'h004) return m[31:0];
            if (a == 12'h008 || a == 12'h00C) return m[63:32];
        end
        return '0;
    endfunction

    task automatic rd(input bit sc, input logic [11:0] a, input string req);
        logic [31:0] got, exp;
        @(negedge clk);
        addr = a;
        #1;
        got = sc ? rdata_s : rdata_d;
        exp = exp_read(sc, a);
        chk(got == exp, req, 64'(got), 64'(exp));
    endtask

    task automatic wr(input bit sc, input logic [11:0] a, input logic [31:0] d,
                      input string req);
        logic [63:0] m, old;
        bit pulse;
        m = sc ? m_s : m_d;
        old = m;
        pulse = 1'b0;
        for (int k = 0; k < 2; k++) begin
            if (!sc && a == 12'(4 * k)) m[k*32 +: 32] = d;
            if (sc && a == 12'(8 * k)) m[k*32 +: 32] = m[k*32 +: 32] | d;
            if (sc && a == 12'(8 * k + 4)) m[k*32 +: 32] = m[k*32 +: 32] & ~d;
        end
        if (a == 12'h000 && d[31]) pulse = 1'b1;
        m[31] = 1'b0;
        @(negedge clk);
        addr = a;
        wdata = d;
        if (sc) we_s = 1'b1; else we_d = 1'b1;
        #1;
        // R7: nothing moves before the accepting edge
        chk((sc ? lines_s : lines_d) == old, "R7 pre-edge", sc ? lines_s : lines_d, old);
        @(negedge clk);
        we_s = 1'b0;
        we_d = 1'b0;
        chk((sc ? lines_s : lines_d) == (m | (64'(pulse) << 31)), req,
            sc ? lines_s : lines_d, m | (64'(pulse) << 31));
        chk((sc ? sys_s : sys_d) == pulse, "R8 pulse", 64'(sc ? sys_s : sys_d), 64'(pulse));
        @(negedge clk);
        chk((sc ? lines_s : lines_d) == m, "R8/R7 after", sc ? lines_s : lines_d, m);
        chk((sc ? sys_s : sys_d) == 1'b0, "R8 one cycle", 64'(sc ? sys_s : sys_d), 64'd0);
        if (sc) m_s = m; else m_d = m;
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
        summary();
    end

    initial begin
        logic [31:0] cur;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(lines_d == '0 && !sys_d, "R1 direct", lines_d, 64'd0);
        chk(lines_s == '0 && !sys_s, "R1 setclr", lines_s, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(lines_d == '0 && lines_s == '0, "R1 after release", lines_d | lines_s, 64'd0);

        // R2, R3, R4: read-modify-write sweep, direct layout
        for (int n = 0; n < 64; n++) begin
            if (n == 31) continue;
            rd(1'b0, 12'(4 * (n / 32)), "R4 read");
            cur = exp_read(1'b0, 12'(4 * (n / 32)));
            wr(1'b0, 12'(4 * (n / 32)), cur | (32'(1) << (n % 32)), "R2/R3 assert");
        end
        for (int n = 0; n < 64; n += 3) begin
            if (n == 31) continue;
            rd(1'b0, 12'(4 * (n / 32)), "R4 read");
            cur = exp_read(1'b0, 12'(4 * (n / 32)));
            wr(1'b0, 12'(4 * (n / 32)), cur & ~(32'(1) << (n % 32)), "R3 release");
        end
        wr(1'b0, 12'h004, 32'h0000_0000, "R3 zero releases");
        wr(1'b0, 12'h000, 32'h5A5A_A5A5 & 32'h7FFF_FFFF, "R3 pattern");
        wr(1'b0, 12'h004, 32'hC3C3_3C3C, "R2/R3 pattern");
        rd(1'b0, 12'h000, "R4 bank0");
        rd(1'b0, 12'h004, "R4 bank1");

        // R7: long hold
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            chk(lines_d == m_d, "R7 hold", lines_d, m_d);
        end

        // R10: enable low ignores bus values
        @(negedge clk);
        addr = 12'h004;
        wdata = 32'hFFFF_FFFF;
        repeat (2) @(negedge clk);
        chk(lines_d == m_d && lines_s == m_s && !sys_d, "R10 no write", lines_d, m_d);

        // R8: system request, direct layout
        rd(1'b0, 12'h000, "R4 before sys");
        cur = exp_read(1'b0, 12'h000);
        wr(1'b0, 12'h000, cur | 32'h8000_0000, "R8 direct");
        rd(1'b0, 12'h000, "R8 bit reads 0");

        // R9: undefined offsets, direct layout
        wr(1'b0, 12'h008, 32'hFFFF_FFFF, "R9 write 0x8");
        wr(1'b0, 12'h00C, 32'hFFFF_FFFF, "R9 write 0xC");
        wr(1'b0, 12'h002, 32'hFFFF_FFFF, "R9 write unaligned");
        wr(1'b0, 12'hFFC, 32'hFFFF_FFFF, "R9 write top");
        rd(1'b0, 12'h008, "R9 read 0x8");
        rd(1'b0, 12'h001, "R9 read unaligned");
        rd(1'b0, 12'hFFC, "R9 read top");

        // R5, R6: set/clear sweep
        for (int n = 0; n < 64; n++) begin
            if (n == 31) continue;
            wr(1'b1, 12'(8 * (n / 32)), 32'(1) << (n % 32), "R5 set");
            rd(1'b1, 12'(8 * (n / 32)), "R6 read set word");
            rd(1'b1, 12'(8 * (n / 32) + 4), "R6 read clear word");
        end
        for (int n = 1; n < 64; n += 2) begin
            if (n == 31) continue;
            wr(1'b1, 12'(8 * (n / 32) + 4), 32'(1) << (n % 32), "R5 clear");
        end
        wr(1'b1, 12'h000, 32'h0000_0000, "R5 zero set");
        wr(1'b1, 12'h00C, 32'h0000_0000, "R5 zero clear");
        wr(1'b1, 12'h00C, 32'h00FF_00FF, "R5 clear pattern");
        wr(1'b1, 12'h008, 32'hF000_000F, "R5 set pattern");
        rd(1'b1, 12'h004, "R6 bank0");
        rd(1'b1, 12'h00C, "R6 bank1");

        // R8: system request, set/clear layout
        wr(1'b1, 12'h000, 32'h8000_0000, "R8 setclr");
        wr(1'b1, 12'h004, 32'h8000_0000, "R8 clear no pulse");
        rd(1'b1, 12'h000, "R8 setclr reads 0");

        // R9: undefined offsets, set/clear layout
        wr(1'b1, 12'h010, 32'hFFFF_FFFF, "R9 sc 0x10");
        wr(1'b1, 12'h006, 32'hFFFF_FFFF, "R9 sc unaligned");
        wr(1'b1, 12'hFFC, 32'hFFFF_FFFF, "R9 sc top");
        rd(1'b1, 12'h010, "R9 sc read 0x10");
        rd(1'b1, 12'h002, "R9 sc read unaligned");

        summary();
    end
endmodule